// File: doc/BRIEF.md
# Lockable Trusted-Load Configuration Register

This block holds one 32-bit configuration word that feeds the clock and low-power control logic. After reset it sits in a pre-boot phase, waiting for a single load strobe carrying a word read from non-volatile configuration storage. The word is taken only when the load is trusted, meaning that neither the read-fail flag nor the blank/erased indication is raised with the strobe. An untrusted load leaves the reset value in place. In either case the pre-boot phase ends, and no later strobe has any effect until the next reset.

Software can write the whole word through a simple bus write port at the register's bank offset. Such a write takes effect only while the externally supplied 2-bit lock field is 00. A matching write attempted under any other lock value is dropped and sets a sticky flag. The flag stays set until reset. The current value is always visible on the output, whatever the lock state.

The control is a two-state machine. `ST_PREBOOT` is entered on reset. It follows the transition `BOOT_CLAIM` to `ST_RUN` on the first load strobe, whether or not that load is trusted. `ST_RUN` holds through the transition `RUN_HOLD` until reset.

Top module: `cfgreg_lockable`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cfg_value` is 0x840E4000 and `wr_locked_err` is 0.
- R2: In the pre-boot phase, a load strobe with `boot_fail`=0 and `boot_blank`=0 makes `cfg_value` equal `boot_word` from the next clock edge onward.
- R3: In the pre-boot phase, a load strobe with `boot_fail`=1 leaves `cfg_value` unchanged.
- R4: In the pre-boot phase, a load strobe with `boot_blank`=1 leaves `cfg_value` unchanged.
- R5: Only the first load strobe after reset is acted on, whether or not it was trusted. Every later strobe leaves `cfg_value` unchanged.
- R6: A bus write with `bus_addr` equal to 0x40 and `lock_sel`=2'b00 sets `cfg_value` to `bus_wdata` at the next clock edge.
- R7: A bus write with `bus_addr` equal to 0x40 and `lock_sel` not equal to 2'b00 leaves `cfg_value` unchanged.
- R8: A bus write with `bus_addr` equal to 0x40 and `lock_sel` not equal to 2'b00 sets `wr_locked_err` to 1. The flag then stays 1 until reset, even across later unlocked writes.
- R9: A bus write with `bus_addr` not equal to 0x40 changes neither `cfg_value` nor `wr_locked_err`.
- R10: When a pre-boot load strobe and an unlocked matching bus write arrive in the same cycle, the load decides the result and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_ld | input | 1 | Pre-boot load strobe |
| boot_word | input | 32 | Configuration word offered with the strobe |
| boot_fail | input | 1 | Load-fail status accompanying the strobe |
| boot_blank | input | 1 | Blank/erased indication accompanying the strobe |
| lock_sel | input | 2 | Lock field; writes are allowed only at 00 |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus write byte offset |
| bus_wdata | input | 32 | Bus write data, full word |
| cfg_value | output | 32 | Current register value |
| wr_locked_err | output | 1 | Sticky flag: a write was attempted while locked |

## Verification
The bench builds the block with its default parameters: a 32-bit word, an 8-bit offset decoded at 0x40, a 2-bit lock and reset value 0x840E4000. With these values every non-zero lock code can be exercised, and a neighbouring offset such as 0x44 can be driven to show that address decoding rejects it. Resets are repeated between scenarios, so that trusted, failed and blank first loads are each seen as the one strobe that ends the pre-boot phase. One scenario drives a load and a write in the same cycle.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
    typedef enum logic [0:0] {
        ST_PREBOOT = 1'b0,
        ST_RUN     = 1'b1
    } boot_state_t;
endpackage

// File: rtl/cfgreg_boot_fsm.sv
module cfgreg_boot_fsm
    import cfgreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_ld,
    input  logic boot_fail,
    input  logic boot_blank,
    output logic load_claim,
    output logic load_take
);
    boot_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PREBOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        load_claim = 1'b0;
        load_take  = 1'b0;
        unique case (state_q)
            ST_PREBOOT: begin
                if (boot_ld) begin
                    load_claim = 1'b1;
                    load_take  = !boot_fail && !boot_blank;
                    state_d    = ST_RUN;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_PREBOOT;
        endcase
    end

    assert_boot_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN && !load_claim));
endmodule

// File: rtl/cfgreg_bus_gate.sv
module cfgreg_bus_gate #(
    parameter int ADDR_W     = 8,
    parameter int LOCK_W     = 2,
    parameter int REG_OFFSET = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LOCK_W-1:0] lock_sel,
    output logic              wr_ok,
    output logic              wr_locked_err
);
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    logic hit, unlocked, err_q;

    assign hit = bus_we && (bus_addr == OFFS);

    generate
        if (LOCK_W == 1) begin : g_lock1
            assign unlocked = !lock_sel[0];
        end else begin : g_lockn
            assign unlocked = (lock_sel == '0);
        end
    endgenerate

    assign wr_ok = hit && unlocked;

    always_ff @(posedge clk) begin
        if (!rst_n)              err_q <= 1'b0;
        else if (hit && !unlocked) err_q <= 1'b1;
    end

    assign wr_locked_err = err_q;

    assert_sticky_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_locked_err |=> wr_locked_err);
    assert_miss_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_locked_err && bus_we && bus_addr != OFFS) |=> !wr_locked_err);
endmodule

// File: rtl/cfgreg_lockable.sv
module cfgreg_lockable #(
    parameter int              DATA_W     = 32,
    parameter int              ADDR_W     = 8,
    parameter int              LOCK_W     = 2,
    parameter int              REG_OFFSET = 'h40,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h840E4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_ld,
    input  logic [DATA_W-1:0] boot_word,
    input  logic              boot_fail,
    input  logic              boot_blank,
    input  logic [LOCK_W-1:0] lock_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] cfg_value,
    output logic              wr_locked_err
);
    logic load_claim, load_take, wr_ok;
    logic [DATA_W-1:0] cfg_q;

    cfgreg_boot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_ld    (boot_ld),
        .boot_fail  (boot_fail),
        .boot_blank (boot_blank),
        .load_claim (load_claim),
        .load_take  (load_take)
    );

    cfgreg_bus_gate #(
        .ADDR_W     (ADDR_W),
        .LOCK_W     (LOCK_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .lock_sel      (lock_sel),
        .wr_ok         (wr_ok),
        .wr_locked_err (wr_locked_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  cfg_q <= RESET_VAL;
        else if (load_take)          cfg_q <= boot_word;
        else if (wr_ok && !load_claim) cfg_q <= bus_wdata;
    end

    assign cfg_value = cfg_q;

    assert_trusted_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_take |=> (cfg_value == $past(boot_word)));
    assert_untrusted_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_claim && (boot_fail || boot_blank)) |=> $stable(cfg_value));
    assert_unlocked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !load_claim) |=> (cfg_value == $past(bus_wdata)));
    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_OFFSET) && lock_sel != '0 && !load_claim)
        |=> $stable(cfg_value));
endmodule

// File: tb/cfgreg_lockable_bench.sv
module cfgreg_lockable_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RST_VAL = 32'h840E4000;
    localparam logic [7:0]  OFFS    = 8'h40;

    typedef struct {
        logic [31:0] val;
        logic        err;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_ld = 1'b0, boot_fail = 1'b0, boot_blank = 1'b0, bus_we = 1'b0;
    logic [31:0] boot_word = '0, bus_wdata = '0;
    logic [1:0]  lock_sel = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] cfg_value;
    logic        wr_locked_err;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t sb[$];

    logic [31:0] m_val;
    logic        m_err;
    bit          m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgreg_lockable u_cfgreg_lockable (
        .clk(clk), .rst_n(rst_n), .boot_ld(boot_ld), .boot_word(boot_word),
        .boot_fail(boot_fail), .boot_blank(boot_blank), .lock_sel(lock_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cfg_value(cfg_value), .wr_locked_err(wr_locked_err)
    );

    // monitor: compare a quarter period after each edge
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (cfg_value !== e.val || wr_locked_err !== e.err) begin
                bad++;
                $display("FAIL %s: value=%h err=%b expected value=%h err=%b",
                         e.req, cfg_value, wr_locked_err, e.val, e.err);
            end
        end
    end

    task automatic push(input string req);
        exp_t e;
        e.val = m_val; e.err = m_err; e.req = req;
        sb.push_back(e);
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        boot_ld = 0; bus_we = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_val = RST_VAL; m_err = 1'b0; m_done = 0;
        @(posedge clk);
        push(req);
    endtask

    task automatic op(input bit ld, input logic [31:0] word, input bit fail,
                      input bit blank, input logic [1:0] lk, input bit we,
                      input logic [7:0] addr, input logic [31:0] data,
                      input string req);
        bit claim;
        @(negedge clk);
        boot_ld = ld; boot_word = word; boot_fail = fail; boot_blank = blank;
        lock_sel = lk; bus_we = we; bus_addr = addr; bus_wdata = data;
        claim = ld && !m_done;
        if (claim) begin
            m_done = 1;
            if (!fail && !blank) m_val = word;
        end
        if (we && addr == OFFS) begin
            if (lk != 2'b00) m_err = 1'b1;
            else if (!claim) m_val = data;
        end
        @(posedge clk);
        push(req);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: value=%h err=%b expected value=done err=done",
                     cfg_value, wr_locked_err);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset("R1");
        // R3 failed load keeps reset value; R5 later trusted strobe ignored
        op(1, 32'h1234_5678, 1, 0, 2'b00, 0, 8'h00, 0, "R3");
        op(1, 32'hCAFE_0001, 0, 0, 2'b00, 0, 8'h00, 0, "R5");
        // R4 blank load
        do_reset("R1");
        op(1, 32'hDEAD_BEEF, 0, 1, 2'b00, 0, 8'h00, 0, "R4");
        op(1, 32'h0F0F_0F0F, 0, 0, 2'b00, 0, 8'h00, 0, "R5");
        // R2 trusted load, R5 second strobe ignored
        do_reset("R1");
        op(1, 32'hA5A5_1234, 0, 0, 2'b00, 0, 8'h00, 0, "R2");
        op(1, 32'h1111_2222, 0, 0, 2'b00, 0, 8'h00, 0, "R5");
        // R6 unlocked write
        op(0, 0, 0, 0, 2'b00, 1, OFFS, 32'h0000_00FF, "R6");
        // R7/R8 locked writes with each non-zero lock code
        op(0, 0, 0, 0, 2'b01, 1, OFFS, 32'h1357_9BDF, "R7");
        op(0, 0, 0, 0, 2'b10, 1, OFFS, 32'h2468_ACE0, "R8");
        op(0, 0, 0, 0, 2'b11, 1, OFFS, 32'hFFFF_FFFF, "R7");
        // R8 sticky across an unlocked write
        op(0, 0, 0, 0, 2'b00, 1, OFFS, 32'h7654_3210, "R8");
        op(0, 0, 0, 0, 2'b00, 0, OFFS, 32'h0, "R8");
        // R9 other offset
        op(0, 0, 0, 0, 2'b00, 1, 8'h44, 32'h9999_9999, "R9");
        // R1 reset clears sticky flag
        do_reset("R1");
        // R9 locked write at other offset leaves flag clear
        op(0, 0, 0, 0, 2'b11, 1, 8'h44, 32'h5555_5555, "R9");
        // R10 load and write same cycle: load wins
        op(1, 32'hB0B0_C0C0, 0, 0, 2'b00, 1, OFFS, 32'h1212_3434, "R10");
        // R10 untrusted load with write: write still dropped
        do_reset("R1");
        op(1, 32'hB0B0_C0C0, 1, 0, 2'b00, 1, OFFS, 32'h1212_3434, "R10");
        // R6 write accepted after pre-boot ends
        op(0, 0, 0, 0, 2'b00, 1, OFFS, 32'h0BAD_F00D, "R6");
        op(0, 0, 0, 0, 2'b00, 0, 8'h00, 0, "R6");
        @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule